// File: doc/BRIEF.md
# Chained Block-Cipher Byte-Stream Wrapper

This block sits between three incoming byte streams and a 128-bit block-cipher core. The streams carry key material, cipher input blocks and an XOR operand, and the block sends back one stream of result bytes. It packs each stream into wide staging buffers. When every buffer that the selected mode needs is full, it pulses the core's start line. When the core reports done, it applies the chosen XOR step and serialises the 16-byte result out through a valid/ready handshake. The core is external and sits behind a simple start/done port.

Chained (CBC) decryption is a matter of configuration. Select the output-side XOR, then feed the operand stream from memory that starts at the initialization vector, which is stored directly in front of the ciphertext. Each decrypted block is then XORed with the preceding ciphertext block, or with the IV for the first block. The key is consumed once per block, so the key source is expected to wrap. The run continues block after block until the block that carries the end-of-stream marker has been drained.

Two write-only registers control the block. The control register holds the key-size code in bits 1:0, a direction bit in bit 2 (set = encrypt, clear = decrypt), a start bit in bit 3 and a keep-enabled bit in bit 4. The data-flow register selects where the XOR operand is applied.

Top module: `cbc_stream_wrap`

## Requirements
- R1: After reset and whenever idle, busy_o is 0, all input ready outputs are 0, out_valid_o is 0 and core_start_o is 0.
- R2: Blocks are packed MSB-first: the first data byte of a block lands in core_din_o[127:120] and the sixteenth in core_din_o[7:0]; the first key byte lands in core_key_o[255:248].
- R3: Key-size codes 0, 1 and 2 take 16, 24 and 32 key bytes per block; key bytes beyond that count are zero, and core_ksize_o shows the code.
- R4: Data-flow code 2 makes each output block equal the core output XOR the operand block.
- R5: Data-flow code 1 feeds the core with data XOR operand and sends out the core output unchanged.
- R6: Data-flow code 0 consumes no operand bytes (xop_ready_o stays 0) and sends out the core output unchanged.
- R7: Control bit 2 drives core_encrypt_o: 1 selects encrypt and 0 selects decrypt.
- R8: A control write with bits 3 and 4 set while idle starts a run, and busy_o is 1 from the following cycle.
- R9: core_start_o is a one-cycle pulse, issued once per block after the key, data and any needed operand bytes are complete. No input byte is accepted while a result is pending or being drained.
- R10: Result bytes leave MSB-first. While out_valid_o is 1 and out_ready_i is 0, the next cycle keeps out_valid_o high and out_data_o unchanged.
- R11: Blocks are processed in turn until the block whose final data byte carried blk_last_i is drained, and then busy_o returns to 0.
- R12: A control write with bit 4 clear aborts the run: it clears all partly filled buffers and returns to idle, so the next run starts clean.
- R13: A data-flow write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control value: [1:0] key size, [2] encrypt, [3] start, [4] keep enabled |
| dflow_we_i | input | 1 | Data-flow register write strobe |
| dflow_wdata_i | input | 2 | Data-flow code: 0 none, 1 XOR at core input, 2 XOR at core output |
| key_valid_i | input | 1 | Key byte valid |
| key_data_i | input | 8 | Key byte |
| key_ready_o | output | 1 | Key byte accepted |
| blk_valid_i | input | 1 | Data byte valid |
| blk_data_i | input | 8 | Data byte |
| blk_last_i | input | 1 | Marks the final byte of the final block |
| blk_ready_o | output | 1 | Data byte accepted |
| xop_valid_i | input | 1 | Operand byte valid |
| xop_data_i | input | 8 | Operand byte |
| xop_ready_o | output | 1 | Operand byte accepted |
| out_valid_o | output | 1 | Result byte valid |
| out_data_o | output | 8 | Result byte |
| out_ready_i | input | 1 | Sink accepts result byte |
| busy_o | output | 1 | Run in progress |
| core_start_o | output | 1 | Start pulse to the cipher core |
| core_encrypt_o | output | 1 | Direction to the core |
| core_ksize_o | output | 2 | Key-size code to the core |
| core_key_o | output | 256 | Packed key block |
| core_din_o | output | 128 | Core input block |
| core_done_i | input | 1 | Core result ready (one-cycle pulse) |
| core_dout_i | input | 128 | Core result block |

## Verification
The main path is tried with every data-flow code, and each code is paired with a different key size, direction and block count. A wrong XOR placement changes the bytes under code 1 or 2 but not under code 0, while a wrong key byte count shifts every later block of a multi-block run. The output sink stalls at a regular interval, which checks that bytes are held during a stall. Directed runs probe MSB-first packing at the core port, an abort in the middle of a block followed by a clean rerun, and a data-flow write during a run.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CORE, ST_DRAIN} wrap_st_e;
  typedef enum logic [1:0] {DF_NONE = 2'd0, DF_IN = 2'd1, DF_OUT = 2'd2, DF_RSVD = 2'd3} dflow_e;
  localparam int unsigned CTRL_START_BIT = 3;
  localparam int unsigned CTRL_KEEP_BIT  = 4;
  localparam int unsigned CTRL_ENC_BIT   = 2;
endpackage

// File: rtl/cbc_byte_stage.sv
module cbc_byte_stage #(
  parameter int unsigned N_BYTES = 16,
  localparam int unsigned CW = $clog2(N_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic [CW-1:0]        need_i,
  input  logic                 valid_i,
  input  logic [7:0]           data_i,
  output logic                 ready_o,
  output logic                 full_o,
  output logic [8*N_BYTES-1:0] buf_o
);
  logic [CW-1:0]        cnt_q;
  logic [8*N_BYTES-1:0] buf_q;

  assign ready_o = en_i && (cnt_q < need_i);
  assign full_o  = (cnt_q == need_i);
  assign buf_o   = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (valid_i && ready_o) begin
      buf_q[8*(N_BYTES-1-int'(cnt_q)) +: 8] <= data_i;  // MSB-first packing
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbc_byte_drain.sv
module cbc_byte_drain #(
  parameter int unsigned N_BYTES = 16,
  localparam int unsigned CW = $clog2(N_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 load_i,
  input  logic [8*N_BYTES-1:0] data_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [7:0]           data_o,
  output logic                 done_o
);
  logic [8*N_BYTES-1:0] sh_q;
  logic [CW-1:0]        cnt_q;
  logic                 valid_q;
  logic                 take;

  assign take    = valid_q && ready_i;
  assign valid_o = valid_q;
  assign data_o  = sh_q[8*N_BYTES-1 -: 8];
  assign done_o  = take && (cnt_q == CW'(N_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= data_i;
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (take) begin
      sh_q  <= {sh_q[8*N_BYTES-9:0], 8'h00};
      cnt_q <= cnt_q + 1'b1;
      if (done_o) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cbc_stream_wrap.sv
module cbc_stream_wrap
  import cbc_pkg::*;
#(
  parameter int unsigned BLK_BYTES      = 16,
  parameter int unsigned KEY_MAX_BYTES  = 32,
  parameter int unsigned KEY_STEP_BYTES = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ctrl_we_i,
  input  logic [4:0]                 ctrl_wdata_i,
  input  logic                       dflow_we_i,
  input  logic [1:0]                 dflow_wdata_i,
  input  logic                       key_valid_i,
  input  logic [7:0]                 key_data_i,
  output logic                       key_ready_o,
  input  logic                       blk_valid_i,
  input  logic [7:0]                 blk_data_i,
  input  logic                       blk_last_i,
  output logic                       blk_ready_o,
  input  logic                       xop_valid_i,
  input  logic [7:0]                 xop_data_i,
  output logic                       xop_ready_o,
  output logic                       out_valid_o,
  output logic [7:0]                 out_data_o,
  input  logic                       out_ready_i,
  output logic                       busy_o,
  output logic                       core_start_o,
  output logic                       core_encrypt_o,
  output logic [1:0]                 core_ksize_o,
  output logic [8*KEY_MAX_BYTES-1:0] core_key_o,
  output logic [8*BLK_BYTES-1:0]     core_din_o,
  input  logic                       core_done_i,
  input  logic [8*BLK_BYTES-1:0]     core_dout_i
);
  localparam int unsigned BLK_W = 8 * BLK_BYTES;
  localparam int unsigned KCW   = $clog2(KEY_MAX_BYTES + 1);
  localparam int unsigned BCW   = $clog2(BLK_BYTES + 1);

  wrap_st_e   st_q;
  dflow_e     df_q;
  logic [1:0] ksize_q;
  logic       enc_q;
  logic       last_q;

  logic           abort, go, load_en, stage_clr, all_full, drain_done, res_load;
  logic           key_full, blk_full, xop_full;
  logic [KCW-1:0] key_need;
  logic [BCW-1:0] xop_need;
  logic [BLK_W-1:0] blk_buf, xop_buf, res;

  assign abort   = ctrl_we_i && !ctrl_wdata_i[CTRL_KEEP_BIT];
  assign go      = ctrl_we_i && ctrl_wdata_i[CTRL_KEEP_BIT] && ctrl_wdata_i[CTRL_START_BIT]
                   && (st_q == ST_IDLE);
  assign load_en = (st_q == ST_LOAD);
  assign res_load  = (st_q == ST_CORE) && core_done_i && !abort;
  assign stage_clr = abort || res_load;
  assign all_full  = key_full && blk_full && xop_full;

  always_comb begin
    int unsigned n;
    n = BLK_BYTES + KEY_STEP_BYTES * int'(ksize_q);
    if (n > KEY_MAX_BYTES) n = KEY_MAX_BYTES;
    key_need = KCW'(n);
  end

  assign xop_need = (df_q == DF_IN || df_q == DF_OUT) ? BCW'(BLK_BYTES) : '0;

  cbc_byte_stage #(.N_BYTES(KEY_MAX_BYTES)) u_key_stage (
    .clk_i, .rst_ni, .clr_i(stage_clr), .en_i(load_en), .need_i(key_need),
    .valid_i(key_valid_i), .data_i(key_data_i), .ready_o(key_ready_o),
    .full_o(key_full), .buf_o(core_key_o)
  );

  cbc_byte_stage #(.N_BYTES(BLK_BYTES)) u_blk_stage (
    .clk_i, .rst_ni, .clr_i(stage_clr), .en_i(load_en), .need_i(BCW'(BLK_BYTES)),
    .valid_i(blk_valid_i), .data_i(blk_data_i), .ready_o(blk_ready_o),
    .full_o(blk_full), .buf_o(blk_buf)
  );

  cbc_byte_stage #(.N_BYTES(BLK_BYTES)) u_xop_stage (
    .clk_i, .rst_ni, .clr_i(stage_clr), .en_i(load_en), .need_i(xop_need),
    .valid_i(xop_valid_i), .data_i(xop_data_i), .ready_o(xop_ready_o),
    .full_o(xop_full), .buf_o(xop_buf)
  );

  assign core_din_o     = (df_q == DF_IN)  ? (blk_buf ^ xop_buf)     : blk_buf;
  assign res            = (df_q == DF_OUT) ? (core_dout_i ^ xop_buf) : core_dout_i;
  assign core_start_o   = load_en && all_full;
  assign core_encrypt_o = enc_q;
  assign core_ksize_o   = ksize_q;
  assign busy_o         = (st_q != ST_IDLE);

  cbc_byte_drain #(.N_BYTES(BLK_BYTES)) u_drain (
    .clk_i, .rst_ni, .clr_i(abort), .load_i(res_load), .data_i(res),
    .ready_i(out_ready_i), .valid_o(out_valid_o), .data_o(out_data_o),
    .done_o(drain_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      df_q    <= DF_NONE;
      ksize_q <= '0;
      enc_q   <= 1'b0;
      last_q  <= 1'b0;
    end else if (abort) begin
      st_q   <= ST_IDLE;
      last_q <= 1'b0;
    end else begin
      if (dflow_we_i && st_q == ST_IDLE) df_q <= dflow_e'(dflow_wdata_i);
      if (ctrl_we_i && st_q == ST_IDLE) begin
        ksize_q <= ctrl_wdata_i[1:0];
        enc_q   <= ctrl_wdata_i[CTRL_ENC_BIT];
      end
      if (blk_valid_i && blk_ready_o && blk_last_i) last_q <= 1'b1;
      unique case (st_q)
        ST_IDLE:  if (go) st_q <= ST_LOAD;
        ST_LOAD:  if (all_full) st_q <= ST_CORE;
        ST_CORE:  if (core_done_i) st_q <= ST_DRAIN;
        ST_DRAIN: if (drain_done) begin
          st_q   <= last_q ? ST_IDLE : ST_LOAD;
          last_q <= 1'b0;
        end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbc_stream_wrap_chk.sv
module cbc_stream_wrap_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic       ctrl_keep_i,
  input logic       busy_o,
  input logic       key_ready_o,
  input logic       blk_ready_o,
  input logic       xop_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_ready_i,
  input logic       core_start_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o && !key_ready_o && !blk_ready_o && !xop_ready_o && !core_start_o);

  assert_start_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);

  assert_no_accept_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !key_ready_o && !blk_ready_o && !xop_ready_o && !core_start_o);

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  assert_abort_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_keep_i |=> !busy_o);
endmodule

bind cbc_stream_wrap cbc_stream_wrap_chk u_chk (
  .clk_i, .rst_ni, .ctrl_we_i, .ctrl_keep_i(ctrl_wdata_i[4]), .busy_o,
  .key_ready_o, .blk_ready_o, .xop_ready_o, .out_valid_o, .out_data_o,
  .out_ready_i, .core_start_o
);

// File: tb/cbc_stream_wrap_test.sv
`timescale 1ns/1ps
module cbc_stream_wrap_test;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         ctrl_we = 1'b0, dflow_we = 1'b0;
  logic [4:0]   ctrl_wdata = '0;
  logic [1:0]   dflow_wdata = '0;
  logic         key_valid = 1'b0, blk_valid = 1'b0, blk_last = 1'b0, xop_valid = 1'b0;
  logic [7:0]   key_data = '0, blk_data = '0, xop_data = '0;
  logic         key_ready_o, blk_ready_o, xop_ready_o, out_valid_o, busy_o;
  logic [7:0]   out_data_o;
  logic         out_ready = 1'b0;
  logic         core_start_o, core_encrypt_o;
  logic [1:0]   core_ksize_o;
  logic [255:0] core_key_o;
  logic [127:0] core_din_o;
  logic         core_done = 1'b0;
  logic [127:0] core_dout = '0;

  int total = 0, bad = 0;
  int starts = 0, xop_hits = 0, drain_acc = 0, core_cnt = 0;
  bit hold_bad = 0;
  logic [127:0] cap_din;
  logic [255:0] cap_key;
  logic         cap_enc;
  logic [1:0]   cap_ks;
  logic [7:0]   got_q [64];

  always #2.5 clk = ~clk;

  cbc_stream_wrap uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .dflow_we_i(dflow_we), .dflow_wdata_i(dflow_wdata),
    .key_valid_i(key_valid), .key_data_i(key_data), .key_ready_o(key_ready_o),
    .blk_valid_i(blk_valid), .blk_data_i(blk_data), .blk_last_i(blk_last), .blk_ready_o(blk_ready_o),
    .xop_valid_i(xop_valid), .xop_data_i(xop_data), .xop_ready_o(xop_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready),
    .busy_o(busy_o), .core_start_o(core_start_o), .core_encrypt_o(core_encrypt_o),
    .core_ksize_o(core_ksize_o), .core_key_o(core_key_o), .core_din_o(core_din_o),
    .core_done_i(core_done), .core_dout_i(core_dout)
  );

  function automatic logic [7:0] kbyte(int s, int i); return 8'(s*7 + i*13 + 1); endfunction
  function automatic logic [7:0] bbyte(int s, int b, int i); return 8'(s*31 + b*17 + i*5 + 3); endfunction
  function automatic logic [7:0] xbyte(int s, int b, int i); return 8'(s*11 + b*29 + i*3 + 7); endfunction

  // Stand-in reversible core
  function automatic logic [127:0] core_f(logic [127:0] d, logic [255:0] k, logic e);
    logic [127:0] t;
    if (e) return {d[119:0], d[127:120]} ^ k[255:128];
    t = d ^ k[255:128];
    return {t[7:0], t[127:8]};
  endfunction

  always @(negedge clk) begin
    if (xop_ready_o) xop_hits++;
    if (out_valid_o && (key_ready_o || blk_ready_o)) drain_acc++;
    if (core_start_o && core_cnt == 0) begin
      cap_din = core_din_o; cap_key = core_key_o;
      cap_enc = core_encrypt_o; cap_ks = core_ksize_o;
      starts++; core_cnt = 3; core_done <= 1'b0;
    end else if (core_cnt > 0) begin
      core_cnt--;
      if (core_cnt == 0) begin
        core_done <= 1'b1;
        core_dout <= core_f(cap_din, cap_key, cap_enc);
      end
    end else core_done <= 1'b0;
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_key(int s, int klen, int count);
    for (int j = 0; j < count; j++) begin
      bit r;
      key_valid = 1'b1; key_data = kbyte(s, j % klen);
      do begin r = key_ready_o; @(posedge clk); @(negedge clk); end while (!r);
    end
    key_valid = 1'b0;
  endtask

  task automatic send_blk(int s, int count, bit mark);
    for (int j = 0; j < count; j++) begin
      bit r;
      blk_valid = 1'b1; blk_data = bbyte(s, j / 16, j % 16);
      blk_last = mark && (j == count - 1);
      do begin r = blk_ready_o; @(posedge clk); @(negedge clk); end while (!r);
    end
    blk_valid = 1'b0; blk_last = 1'b0;
  endtask

  task automatic send_xop(int s, int count);
    for (int j = 0; j < count; j++) begin
      bit r;
      xop_valid = 1'b1; xop_data = xbyte(s, j / 16, j % 16);
      do begin r = xop_ready_o; @(posedge clk); @(negedge clk); end while (!r);
    end
    xop_valid = 1'b0;
  endtask

  task automatic recv(int count);
    int idx = 0, cyc = 0;
    bit pstall = 0;
    logic [7:0] pd = '0;
    while (idx < count) begin
      bit v;
      logic [7:0] d;
      out_ready = (cyc % 3) != 2;
      v = out_valid_o; d = out_data_o;
      if (pstall && !(v && d == pd)) hold_bad = 1;
      pstall = v && !out_ready; pd = d;
      @(posedge clk); @(negedge clk);
      if (v && out_ready) begin got_q[idx] = d; idx++; end
      cyc++;
    end
    out_ready = 1'b0;
  endtask

  task automatic write_regs(bit wc, logic [4:0] c, bit wd, logic [1:0] d);
    ctrl_we = wc; ctrl_wdata = c; dflow_we = wd; dflow_wdata = d;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0; dflow_we = 1'b0;
  endtask

  task automatic run(int ks, bit enc, int md, int nb, int s, bit poke, string tag);
    int klen = (ks == 0) ? 16 : (ks == 1) ? 24 : 32;
    int s0 = starts, x0 = xop_hits, d0 = drain_acc;
    logic [255:0] kv = '0;
    hold_bad = 0;
    for (int i = 0; i < klen; i++) kv[255-8*i -: 8] = kbyte(s, i);
    write_regs(1, {1'b1, 1'b1, enc, 2'(ks)}, 1, 2'(md));
    chk(busy_o == 1'b1, "R8", 128'(busy_o), 128'(1));
    fork
      send_key(s, klen, klen * nb);
      send_blk(s, 16 * nb, 1);
      if (md != 0) send_xop(s, 16 * nb);
      recv(16 * nb);
      if (poke) begin repeat (2) @(negedge clk); write_regs(0, '0, 1, 2'd2); end
    join
    repeat (2) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      logic [127:0] din, xo, exp, act;
      for (int i = 0; i < 16; i++) begin
        din[127-8*i -: 8] = bbyte(s, b, i);
        xo[127-8*i -: 8]  = xbyte(s, b, i);
        act[127-8*i -: 8] = got_q[16*b + i];
      end
      if (md == 1) din = din ^ xo;
      exp = core_f(din, kv, enc);
      if (md == 2) exp = exp ^ xo;
      chk(act == exp, tag, act, exp);
    end
    chk(starts - s0 == nb, "R9", 128'(starts - s0), 128'(nb));
    chk(drain_acc == d0, "R9", 128'(drain_acc - d0), 128'(0));
    chk(cap_ks == 2'(ks), "R3", 128'(cap_ks), 128'(ks));
    chk(cap_enc == enc, "R7", 128'(cap_enc), 128'(enc));
    chk(busy_o == 1'b0, "R11", 128'(busy_o), 128'(0));
    chk(hold_bad == 0, "R10", 128'(hold_bad), 128'(0));
    if (md == 0) chk(xop_hits == x0, "R6", 128'(xop_hits - x0), 128'(0));
  endtask

  // {ksize, encrypt, dflow, blocks, seed}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 1'b0, 2'd2, 3'd3, 8'd1},
    {2'd1, 1'b1, 2'd1, 3'd2, 8'd2},
    {2'd2, 1'b0, 2'd0, 3'd1, 8'd3},
    {2'd2, 1'b1, 2'd2, 3'd2, 8'd4},
    {2'd0, 1'b1, 2'd0, 3'd2, 8'd5},
    {2'd1, 1'b0, 2'd2, 3'd1, 8'd6}
  };

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy_o == 0, "R1", 128'(busy_o), 0);
    chk({key_ready_o, blk_ready_o, xop_ready_o} == 3'b000, "R1",
        128'({key_ready_o, blk_ready_o, xop_ready_o}), 0);
    chk({out_valid_o, core_start_o} == 2'b00, "R1", 128'({out_valid_o, core_start_o}), 0);

    for (int v = 0; v < 6; v++) begin
      int md = int'(VEC[v][12:11]);
      run(int'(VEC[v][15:14]), VEC[v][13], md, int'(VEC[v][10:8]), int'(VEC[v][7:0]), 0,
          md == 2 ? "R4" : md == 1 ? "R5" : "R6");
    end

    // R2/R3 packing at the core port, single block, 16-byte key
    run(0, 1, 0, 1, 9, 0, "R2");
    chk(cap_din[127:120] == bbyte(9, 0, 0), "R2", 128'(cap_din[127:120]), 128'(bbyte(9, 0, 0)));
    chk(cap_din[7:0] == bbyte(9, 0, 15), "R2", 128'(cap_din[7:0]), 128'(bbyte(9, 0, 15)));
    chk(cap_key[255:248] == kbyte(9, 0), "R2", 128'(cap_key[255:248]), 128'(kbyte(9, 0)));
    chk(cap_key[127:0] == '0, "R3", cap_key[127:0], '0);

    // R13 data-flow write during a run is ignored
    run(1, 0, 0, 2, 10, 1, "R13");

    // R12 abort mid-block, then clean rerun
    write_regs(1, 5'b11000, 1, 2'd0);
    fork
      send_key(11, 16, 5);
      send_blk(11, 3, 0);
    join
    write_regs(1, 5'b00000, 0, 2'd0);
    chk(busy_o == 0, "R12", 128'(busy_o), 0);
    chk({key_ready_o, blk_ready_o} == 2'b00, "R12", 128'({key_ready_o, blk_ready_o}), 0);
    run(0, 0, 2, 1, 12, 0, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule